// File: doc/BRIEF.md
# Vectored Interrupt and Trap Controller

This block sits beside a small processor core and decides when, and to where, the core must leave its normal instruction stream. It watches up to thirteen level-sensitive maskable requests and two trap requests. For a maskable request it picks the most urgent enabled source and issues a one-cycle branch strobe with the fixed vector of that source. It also pulses an acknowledge back to the devices and raises an in-service flag that stays high until the core reports a return from the service routine. The source count is a parameter, normally 11 or 13.

The core reports status every cycle. A retire strobe says that an instruction completes in this cycle. An interruptible flag qualifies that instruction. A return strobe marks the end of a service routine. A maskable request is taken only when an interruptible instruction retires and no routine is in service. Branches, loops and the like therefore defer it until the next interruptible instruction completes. Traps ignore both of these gates: a rising edge on a trap request forces a branch on the next clock edge, whatever the core is doing.

All pins are plain control signals. The branch strobe has no back-pressure: the core must accept a vector on the cycle it appears. Stacking of return state, the pipeline and the routines themselves belong elsewhere.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, br_req, irq_ack and in_service are low and every mask bit is 0, which means every maskable source is disabled.
- R2: A write with mask_we high loads mask_wdata into the mask from the next cycle on. Mask bit i set to 1 enables source i. A source whose bit is 0 is never taken, whatever its request does.
- R3: With the default parameters, maskable source i branches to 0x0010 + 4*i, and trap j branches to 0x0008 + 4*j.
- R4: Among the enabled sources whose request is high, the one with the lowest index is taken. The others are served later, one after another, in index order.
- R5: A maskable source is taken only on an edge where core_retire and core_intable are both 1. A request held through non-interruptible or non-retiring cycles is taken at the first interruptible retire.
- R6: While in_service is 1, no maskable source is taken.
- R7: core_rti clears in_service on the next edge. The next maskable source may then be taken from the following interruptible retire.
- R8: A take shows up on the edge that samples it: br_req and br_vec appear on that edge, irq_ack goes high for that one cycle for maskable sources only, and in_service goes to 1.
- R9: Requests are levels and are never latched. A request dropped before it is taken is lost. A request still held after its routine returns is taken again.
- R10: A 0-to-1 change on trap_req[j] issues a branch to the trap vector on the next edge, even when core_retire or core_intable is 0 or in_service is 1. irq_ack stays low and in_service becomes 1. A trap request that stays high does not branch again.
- R11: Trap 0 outranks trap 1. When both rise together, trap 0 branches first and trap 1 branches on the next edge. Any trap outranks a maskable source on the same edge, and that maskable source is deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_IRQ | Level maskable requests, bit 0 most urgent |
| trap_req | input | 2 | Trap requests, acted on at the rising edge |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_IRQ | New mask value, 1 = enabled |
| core_retire | input | 1 | An instruction completes this cycle |
| core_intable | input | 1 | The completing instruction is interruptible |
| core_rti | input | 1 | Return from a service routine |
| br_req | output | 1 | One-cycle branch strobe to the core |
| br_vec | output | VEC_W | Branch target address, valid with br_req |
| irq_ack | output | 1 | One-cycle acknowledge for a maskable take |
| in_service | output | 1 | A service routine is active |

## Verification
The bench goes after priority across every pair of sources. An encoder that favours the wrong end, or that drops the loser instead of serving it after the return, would give the wrong second vector. It checks deferral under non-interruptible and non-retiring cycles, and under an active routine. A controller that ignored either gate would branch early, and one that forgot to clear the flag on return would never branch again. Trap cases cover a trap arriving mid-routine, both traps rising together and a trap colliding with a maskable take. A wrong design here would lose trap 1, re-fire on a held trap, or acknowledge a trap. Single-bit mask sweeps and short pulses catch latched requests and mask bits that do not line up with their sources.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Which kind of source produced a branch
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TRAP = 2'd1,
    SRC_IRQ  = 2'd2
  } src_kind_e;

  // Branch target of slot idx in a table starting at base
  function automatic logic [31:0] slot_addr(input logic [31:0] base,
                                            input int unsigned stride,
                                            input int unsigned idx);
    return base + 32'(idx * stride);
  endfunction

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en
);

  always_ff @(posedge clk) begin
    if (!rst_n)  en <= '0;
    else if (we) en <= wdata;
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 13,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          vld,
  output logic [IW-1:0] idx
);

  logic [N-1:0] grant;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // one-hot view for checking
  for (genvar g = 0; g < N; g++) begin : g_grant
    assign grant[g] = vld && (idx == IW'(g));
  end

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (((grant - 1'b1) & req) == '0) && ((grant & req) == grant));

endmodule

// File: rtl/irq_trap_unit.sv
module irq_trap_unit #(
  parameter int unsigned NT = 2,
  localparam int unsigned TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] trap_req,
  output logic          go,
  output logic [TW-1:0] sel
);

  logic [NT-1:0] prev_q;
  logic [NT-1:0] pend_q;
  logic [NT-1:0] cand;
  logic [NT-1:0] taken;

  // new rising edges join the traps still waiting
  assign cand = pend_q | (trap_req & ~prev_q);

  always_comb begin
    go  = 1'b0;
    sel = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (cand[i]) begin
        go  = 1'b1;
        sel = TW'(i);
      end
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_take
    assign taken[g] = go && (sel == TW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= trap_req;
      pend_q <= cand & ~taken;
    end
  end

  // R11
  trap0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req[0]) |-> (go && sel == '0));

  // R10
  trap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req != '0 && pend_q == '0 && $past(trap_req) == '0) |-> go);

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int unsigned NUM_IRQ    = 13,
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned TRAP_BASE  = 32'h0008,
  parameter int unsigned IRQ_BASE   = 32'h0010,
  parameter int unsigned VEC_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [1:0]         trap_req,
  input  logic               mask_we,
  input  logic [NUM_IRQ-1:0] mask_wdata,
  input  logic               core_retire,
  input  logic               core_intable,
  input  logic               core_rti,
  output logic               br_req,
  output logic [VEC_W-1:0]   br_vec,
  output logic               irq_ack,
  output logic               in_service
);
  import irq_vec_pkg::*;

  localparam int unsigned IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] en;
  logic [NUM_IRQ-1:0] elig;
  logic               enc_vld;
  logic [IW-1:0]      enc_idx;
  logic               trap_go;
  logic               trap_sel;
  logic               irq_go;
  src_kind_e          kind;
  logic [31:0]        tgt;

  irq_mask_reg #(.N(NUM_IRQ)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(mask_wdata), .en(en)
  );

  assign elig = irq_req & en;

  irq_prio_enc #(.N(NUM_IRQ)) u_enc (
    .clk(clk), .rst_n(rst_n), .req(elig), .vld(enc_vld), .idx(enc_idx)
  );

  irq_trap_unit #(.NT(2)) u_trap (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .go(trap_go), .sel(trap_sel)
  );

  // maskable take: interruptible retire, nothing in service, no trap now
  assign irq_go = core_retire && core_intable && !in_service && enc_vld && !trap_go;

  always_comb begin
    if (trap_go)     kind = SRC_TRAP;
    else if (irq_go) kind = SRC_IRQ;
    else             kind = SRC_NONE;
  end

  always_comb begin
    case (kind)
      SRC_TRAP: tgt = slot_addr(TRAP_BASE, VEC_STRIDE, 32'(trap_sel));
      SRC_IRQ:  tgt = slot_addr(IRQ_BASE, VEC_STRIDE, 32'(enc_idx));
      default:  tgt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_req     <= 1'b0;
      br_vec     <= '0;
      irq_ack    <= 1'b0;
      in_service <= 1'b0;
    end else begin
      br_req  <= (kind != SRC_NONE);
      irq_ack <= (kind == SRC_IRQ);
      if (kind != SRC_NONE) begin
        br_vec     <= tgt[VEC_W-1:0];
        in_service <= 1'b1;
      end else if (core_rti) begin
        in_service <= 1'b0;
      end
    end
  end

  // R8
  ack_with_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (br_req && in_service));

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R6
  no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(!in_service));

  // R5
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(core_retire && core_intable));

  // R7
  rti_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rti && !trap_go && !irq_go) |=> !in_service);

endmodule

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;

  localparam int N = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic [1:0]   trap_req = '0;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic         core_retire = 1'b0;
  logic         core_intable = 1'b0;
  logic         core_rti = 1'b0;
  logic         br_req;
  logic [15:0]  br_vec;
  logic         irq_ack;
  logic         in_service;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trap_req(trap_req),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .core_retire(core_retire),
    .core_intable(core_intable), .core_rti(core_rti), .br_req(br_req),
    .br_vec(br_vec), .irq_ack(irq_ack), .in_service(in_service)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ivec(input int k);
    return 32'h10 + 32'(4 * k);
  endfunction

  // finish a routine: drop requests given, pulse return
  task automatic ret_all();
    core_retire = 1'b0;
    core_rti = 1'b1;
    tick();
    core_rti = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 br_req", 32'(br_req), 0);
    chk("R1 ack", 32'(irq_ack), 0);
    chk("R1 in_service", 32'(in_service), 0);
    rst_n = 1'b1;
    tick();
    // R1/R2 mask cleared: nothing taken with all requests high
    irq_req = '1; core_retire = 1; core_intable = 1;
    tick();
    chk("R1 R2 masked no take", 32'(br_req), 0);
    irq_req = '0; core_retire = 0;

    // R2 one enabled bit at a time, all requests high
    for (int k = 0; k < N; k++) begin
      mask_we = 1; mask_wdata = N'(1) << k;
      tick();
      mask_we = 0;
      irq_req = '1; core_retire = 1; core_intable = 1;
      tick();
      chk("R2 single enable vec", br_vec, ivec(k));
      chk("R2 single enable take", 32'(br_req), 1);
      irq_req = '0;
      ret_all();
    end
    mask_we = 1; mask_wdata = '1;
    tick();
    mask_we = 0;

    // R3 R8 single sources
    for (int k = 0; k < N; k++) begin
      irq_req = N'(1) << k; core_retire = 1; core_intable = 1;
      tick();
      chk("R3 vector", br_vec, ivec(k));
      chk("R8 ack", 32'(irq_ack), 1);
      chk("R8 in_service", 32'(in_service), 1);
      irq_req = '0; core_retire = 0;
      tick();
      chk("R8 strobe one cycle", 32'({br_req, irq_ack}), 0);
      ret_all();
      chk("R7 cleared", 32'(in_service), 0);
    end

    // R4 R7 every pair: lower first, other after return
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        irq_req = (N'(1) << a) | (N'(1) << b); core_retire = 1; core_intable = 1;
        tick();
        chk("R4 winner", br_vec, ivec(a));
        irq_req[a] = 1'b0;
        tick();
        chk("R6 held while in service", 32'(br_req), 0);
        ret_all();
        core_retire = 1; core_intable = 1;
        tick();
        chk("R4 R7 loser next", br_vec, ivec(b));
        chk("R4 R7 loser ack", 32'(irq_ack), 1);
        irq_req = '0;
        ret_all();
      end
    end

    // R5 deferral
    irq_req = N'(1) << 4; core_retire = 1; core_intable = 0;
    tick();
    chk("R5 noninterruptible defers", 32'(br_req), 0);
    core_retire = 0; core_intable = 1;
    tick();
    chk("R5 no retire defers", 32'(br_req), 0);
    core_retire = 1;
    tick();
    chk("R5 taken at interruptible retire", br_vec, ivec(4));
    irq_req = '0;
    ret_all();

    // R9 lost pulse
    irq_req = N'(1) << 5; core_retire = 1; core_intable = 0;
    tick();
    irq_req = '0; core_intable = 1;
    tick();
    chk("R9 dropped pulse lost", 32'(br_req), 0);
    core_retire = 0;
    // R9 held request taken again
    irq_req = N'(1) << 7; core_retire = 1;
    tick();
    chk("R9 first take", br_vec, ivec(7));
    ret_all();
    core_retire = 1;
    tick();
    chk("R9 taken again", br_vec, ivec(7));
    chk("R9 ack again", 32'(irq_ack), 1);
    irq_req = '0;
    ret_all();

    // R10 trap mid-routine and non-interruptible
    irq_req = N'(1) << 3; core_retire = 1; core_intable = 1;
    tick();
    irq_req = '0; core_intable = 0; trap_req = 2'b01;
    tick();
    chk("R10 trap vec", br_vec, 32'h8);
    chk("R10 trap strobe", 32'(br_req), 1);
    chk("R10 trap no ack", 32'(irq_ack), 0);
    tick();
    chk("R10 held trap no refire", 32'(br_req), 0);
    trap_req = 2'b00;
    ret_all();
    // trap while idle without retire
    trap_req = 2'b10;
    tick();
    chk("R10 trap1 vec", br_vec, 32'hC);
    chk("R10 in_service", 32'(in_service), 1);
    trap_req = 2'b00;
    ret_all();

    // R11 both traps together
    trap_req = 2'b11;
    tick();
    chk("R11 trap0 first", br_vec, 32'h8);
    tick();
    chk("R11 trap1 next", br_vec, 32'hC);
    chk("R11 trap1 strobe", 32'(br_req), 1);
    tick();
    chk("R11 no third", 32'(br_req), 0);
    trap_req = 2'b00;
    ret_all();

    // R11 trap beats maskable on same edge
    irq_req = N'(1) << 2; trap_req = 2'b10; core_retire = 1; core_intable = 1;
    tick();
    chk("R11 trap over irq", br_vec, 32'hC);
    chk("R11 no ack", 32'(irq_ack), 0);
    tick();
    chk("R11 irq deferred", 32'(br_req), 0);
    trap_req = 2'b00;
    ret_all();
    core_retire = 1;
    tick();
    chk("R11 irq after return", br_vec, ivec(2));
    irq_req = '0;
    ret_all();

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule